// File: doc/BRIEF.md
# Serial Memory Bus Cycle Sequencer

This block is the host-side master for a serial memory that has a single data pin. It takes one command at a time from a valid/ready request port and expands it into an ordered train of single-bit bus cycles on the chip-enable, output-enable and write-enable strobes and a tristate data line. It supports three commands. A page write loads 1 to 8 bytes and then commits them. A byte read returns one byte. A status poll waits for an internal write to finish.

Each bus cycle has the same shape. The chip enable and exactly one of the two strobes are held low for `PULSE` clocks. All strobes are then held high for `GAP` clocks, which releases the bus between cycles. A write cycle drives one bit on the data line. A read cycle samples the data line on the last clock of its strobe. Every write and read starts with a wake-up preamble. In this block the preamble is a parameterised stub of `RST_LEN` read cycles. After a commit, the block keeps issuing read cycles until the line reads high. It gives up after `POLL_MAX` reads. The result is returned as a one-clock response carrying an error code and, for reads, the byte.

Top module: `strobe_seq`

## Requirements
- R1: After reset, and whenever no command is running, ce_n, oe_n and we_n are all 1, io_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: Every bus cycle holds ce_n low together with exactly one of oe_n or we_n for exactly PULSE clocks. The cycle is followed by at least GAP clocks with all three strobes high. oe_n and we_n are never low together.
- R3: The data line is driven (io_oe=1) only while we_n is low. A read cycle samples io_in on the last clock of its oe_n pulse.
- R4: A page write (req_op=2'b00) issues these cycles in order:
  - RST_LEN read cycles;
  - 16 address write cycles carrying {7'b0, req_addr[8:0]}, MSB first;
  - the data bits;
  - one read cycle, one write cycle carrying 1, and one more read cycle;
  - status read cycles.
- R5: req_len (3 bits) encodes the byte count minus one, so a write carries 8 to 64 data bits in whole bytes. The byte for address req_addr+k is req_data[8k+7:8k]. Bytes are sent in increasing k, and each byte is sent bit 7 first.
- R6: A page write whose req_addr[2:0] + req_len exceeds 7 is refused. The next clock gives rsp_valid with rsp_err=1, and no bus cycle is issued.
- R7: Status read cycles repeat until a read samples io_in=1. The response then carries rsp_err=0.
- R8: If POLL_MAX consecutive status reads all sample 0, the block stops and responds with rsp_err=2.
- R9: A byte read (req_op=2'b01) issues these cycles:
  - RST_LEN read cycles;
  - the 16 address write cycles;
  - 8 read cycles.
  The first sampled bit is bit 7 of rsp_data. rsp_err is 0, and rsp_data is defined only for this command.
- R10: A status poll (req_op=2'b10 or 2'b11) issues only the status read cycles of R7/R8.
- R11: req_ready is 1 only when idle, so requests offered while a command runs are ignored. rsp_valid is a single-clock pulse, after which req_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command accepted this clock (idle) |
| req_op | input | 2 | 00 page write, 01 byte read, 1x status poll |
| req_addr | input | 9 | Byte address |
| req_len | input | 3 | Write byte count minus one |
| req_data | input | 64 | Write bytes, byte k at bits 8k+7:8k |
| rsp_valid | output | 1 | One-clock response strobe |
| rsp_err | output | 2 | 0 ok, 1 page crossing, 2 poll timeout |
| rsp_data | output | 8 | Byte returned by a read |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable (read strobe), active low |
| we_n | output | 1 | Write enable (write strobe), active low |
| io_out | output | 1 | Bit driven on the data line |
| io_oe | output | 1 | Drive enable for the data line |
| io_in | input | 1 | Value sampled from the data line |

## Verification
Writes are tried with several lengths and start offsets:
- a single byte;
- a full aligned page;
- a mid-page run that ends exactly on the last byte of the page;
- a run one byte longer, which must be refused.

Together these separate the page-boundary test from the data-length count. Reads use bytes with mixed and lone set bits, so that a reversed bit order or an off-by-one sample is visible. Polls are given busy spans of zero, a few, one short of the limit and exactly the limit, which separates normal completion from timeout. An unknown opcode, a request held high while busy, and a reset in mid-transaction cover the handshake and idle rules.

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int PULSE    = 3,
  parameter int GAP      = 2,
  parameter int RST_LEN  = 2,
  parameter int POLL_MAX = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [8:0]  req_addr,
  input  logic [2:0]  req_len,
  input  logic [63:0] req_data,
  output logic        rsp_valid,
  output logic [1:0]  rsp_err,
  output logic [7:0]  rsp_data,
  output logic        ce_n,
  output logic        oe_n,
  output logic        we_n,
  output logic        io_out,
  output logic        io_oe,
  input  logic        io_in
);
  localparam int CYC = PULSE + GAP;
  localparam int PW  = $clog2(CYC + 1);
  localparam int CW  = $clog2((POLL_MAX > 64 ? POLL_MAX : 64) + 1);

  typedef enum logic [3:0] {IDLE, RST, ADDR, DATA, C1, C2, C3, RDAT, POLL, RSP} st_t;

  st_t          st;
  logic [PW-1:0] ph;
  logic [CW-1:0] cnt;
  logic          wr_op, smp;
  logic [8:0]    addr;
  logic [63:0]   dsr;
  logic [6:0]    nbits;
  logic [7:0]    rsr;
  logic [1:0]    err;
  logic          active, wr_cyc, pulse, last, bit_c;
  logic [15:0]   addr16;

  assign addr16 = {7'b0, addr};
  assign active = (st != IDLE) && (st != RSP);
  assign wr_cyc = (st == ADDR) || (st == DATA) || (st == C2);
  assign pulse  = active && (ph < PW'(PULSE));
  assign last   = (ph == PW'(CYC - 1));

  always_comb begin
    unique case (st)
      ADDR:    bit_c = addr16[4'd15 - cnt[3:0]];
      DATA:    bit_c = dsr[63];
      C2:      bit_c = 1'b1;
      default: bit_c = 1'b0;
    endcase
  end

  assign ce_n      = !pulse;
  assign we_n      = !(pulse && wr_cyc);
  assign oe_n      = !(pulse && !wr_cyc);
  assign io_oe     = pulse && wr_cyc;
  assign io_out    = io_oe & bit_c;
  assign req_ready = (st == IDLE);
  assign rsp_valid = (st == RSP);
  assign rsp_err   = err;
  assign rsp_data  = rsr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0; cnt <= '0; wr_op <= 1'b0; smp <= 1'b0;
      addr <= '0; dsr <= '0; nbits <= '0; rsr <= '0; err <= '0;
    end else begin
      unique case (st)
        IDLE: if (req_valid) begin
          ph    <= '0;
          cnt   <= '0;
          err   <= 2'd0;
          addr  <= req_addr;
          nbits <= 7'({req_len, 3'b000}) + 7'd8;
          for (int k = 0; k < 8; k++) dsr[63-8*k -: 8] <= req_data[8*k +: 8];
          if (req_op == 2'b00) begin
            wr_op <= 1'b1;
            if ({1'b0, req_addr[2:0]} + {1'b0, req_len} > 4'd7) begin
              err <= 2'd1;
              st  <= RSP;
            end else st <= RST;
          end else if (req_op == 2'b01) begin
            wr_op <= 1'b0;
            st    <= RST;
          end else st <= POLL;
        end
        RSP: st <= IDLE;
        default: begin
          ph <= last ? '0 : ph + 1'b1;
          if (ph == PW'(PULSE - 1) && !wr_cyc) begin
            smp <= io_in;
            if (st == RDAT) rsr <= {rsr[6:0], io_in};
          end
          if (last) begin
            unique case (st)
              RST:  if (cnt == CW'(RST_LEN - 1)) begin st <= ADDR; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
              ADDR: if (cnt == CW'(15)) begin st <= wr_op ? DATA : RDAT; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
              DATA: begin
                dsr <= dsr << 1;
                if (cnt == CW'(nbits - 7'd1)) begin st <= C1; cnt <= '0; end
                else cnt <= cnt + 1'b1;
              end
              C1:   st <= C2;
              C2:   st <= C3;
              C3:   begin st <= POLL; cnt <= '0; end
              RDAT: if (cnt == CW'(7)) st <= RSP;
                    else cnt <= cnt + 1'b1;
              POLL: if (smp) st <= RSP;
                    else if (cnt == CW'(POLL_MAX - 1)) begin st <= RSP; err <= 2'd2; end
                    else cnt <= cnt + 1'b1;
              default: st <= IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic [8:0] req_addr,
  input logic [2:0] req_len,
  input logic       rsp_valid,
  input logic [1:0] rsp_err,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       io_oe
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && !we_n)); // R2
  AST_CE_GATES: assert property (@(posedge clk) disable iff (!rst_n) ce_n |-> (oe_n && we_n)); // R2
  AST_DRIVE_WR: assert property (@(posedge clk) disable iff (!rst_n) io_oe |-> (!we_n && !ce_n)); // R3
  AST_PAGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b00 && ({1'b0, req_addr[2:0]} + {1'b0, req_len} > 4'd7))
    |=> (rsp_valid && rsp_err == 2'd1 && ce_n)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |-> !req_ready); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> (!rsp_valid && req_ready)); // R11
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_err != 2'd3); // R8
endmodule

bind strobe_seq strobe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .io_oe(io_oe)
);

// File: tb/strobe_seq_tb.sv
module strobe_seq_tb;
  localparam int PULSE = 2, GAP = 1, RST_LEN = 2, POLL_MAX = 6;

  typedef struct packed {
    logic [1:0]  op;
    logic [8:0]  addr;
    logic [2:0]  len;
    logic [63:0] data;
    logic [3:0]  busy;
    logic [1:0]  err;
    logic [7:0]  rbyte;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 9'h000, 3'd0, 64'h00000000000000A5, 4'd2, 2'd0, 8'h00},
    '{2'd0, 9'h1F8, 3'd7, 64'h0123456789ABCDEF, 4'd0, 2'd0, 8'h00},
    '{2'd0, 9'h0C3, 3'd4, 64'h0000001122334455, 4'd5, 2'd0, 8'h00},
    '{2'd0, 9'h0C4, 3'd4, 64'h0000001122334455, 4'd0, 2'd1, 8'h00},
    '{2'd1, 9'h155, 3'd0, 64'h0,                4'd0, 2'd0, 8'h96},
    '{2'd1, 9'h000, 3'd0, 64'h0,                4'd0, 2'd0, 8'h01},
    '{2'd2, 9'h000, 3'd0, 64'h0,                4'd3, 2'd0, 8'h00},
    '{2'd2, 9'h000, 3'd0, 64'h0,                4'd6, 2'd2, 8'h00},
    '{2'd0, 9'h010, 3'd1, 64'h000000000000C33C, 4'd9, 2'd2, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [8:0] req_addr = 0;
  logic [2:0] req_len = 0;
  logic [63:0] req_data = 0;
  logic rsp_valid;
  logic [1:0] rsp_err;
  logic [7:0] rsp_data;
  logic ce_n, oe_n, we_n, io_out, io_oe, io_in;

  always #2 clk = ~clk;

  strobe_seq #(.PULSE(PULSE), .GAP(GAP), .RST_LEN(RST_LEN), .POLL_MAX(POLL_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int checks = 0, fails = 0;
  logic [0:127] rv;
  int rd_idx = 0, rd_base = 0;
  assign io_in = rv[7'(rd_idx - rd_base)];

  logic lt [4096];
  logic lb [4096];
  int log_n = 0;
  logic et [128];
  logic eb [128];
  int exp_n;
  int werr = 0, derr = 0, lo = 0, hi = 100;
  logic p_we = 1, p_oe = 1, p_ce = 1;

  always @(negedge clk) begin
    if (p_we && !we_n) begin lt[log_n] <= 1; lb[log_n] <= io_out; log_n <= log_n + 1; end
    if (p_oe && !oe_n) begin lt[log_n] <= 0; lb[log_n] <= 0; log_n <= log_n + 1; end
    if (!p_oe && oe_n) rd_idx <= rd_idx + 1;
    if (!we_n && !io_oe) derr <= derr + 1;
    if (!(we_n && oe_n)) lo <= lo + 1;
    else if (lo != 0) begin if (lo != PULSE && rst_n) werr <= werr + 1; lo <= 0; end
    if (ce_n) hi <= hi + 1;
    else if (p_ce) begin if (hi < GAP) werr <= werr + 1; hi <= 0; end
    p_we <= we_n; p_oe <= oe_n; p_ce <= ce_n;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv); end
  endtask

  task automatic push(input logic t, input logic b);
    et[exp_n] = t; eb[exp_n] = b; exp_n++;
  endtask

  task automatic prep(input vec_t v, input logic [1:0] op);
    int np;
    bit rej;
    logic [15:0] a16;
    rv = '1; exp_n = 0;
    a16 = {7'b0, v.addr};
    np = (int'(v.busy) >= POLL_MAX) ? POLL_MAX : int'(v.busy) + 1;
    rej = (op == 2'b00) && (int'(v.addr[2:0]) + int'(v.len) > 7);
    if (rej) return;
    if (op[1] == 1'b0) begin
      for (int i = 0; i < RST_LEN; i++) begin push(0, 0); rv[i] = 0; end
      for (int i = 15; i >= 0; i--) push(1, a16[i]);
    end
    if (op == 2'b00) begin
      for (int k = 0; k <= int'(v.len); k++)
        for (int i = 7; i >= 0; i--) push(1, v.data[8*k + i]);
      push(0, 0); push(1, 1); push(0, 0);
      rv[RST_LEN] = 0; rv[RST_LEN+1] = 0;
      for (int i = 0; i < np; i++) push(0, 0);
      for (int i = 0; i < int'(v.busy) && i < 100; i++) rv[RST_LEN + 2 + i] = 0;
    end else if (op == 2'b01) begin
      for (int i = 0; i < 8; i++) begin push(0, 0); rv[RST_LEN + i] = v.rbyte[7-i]; end
    end else begin
      for (int i = 0; i < np; i++) push(0, 0);
      for (int i = 0; i < int'(v.busy); i++) rv[i] = 0;
    end
  endtask

  task automatic run(input vec_t v, input logic [1:0] op, input bit hold, input string tag);
    int base, n, bad;
    logic [1:0] e;
    logic [7:0] d;
    prep(v, op);
    @(negedge clk);
    base = log_n; rd_base = rd_idx;
    req_op = op; req_addr = v.addr; req_len = v.len; req_data = v.data; req_valid = 1;
    @(negedge clk);
    if (!hold) req_valid = 0; else req_op = 2'b00;
    n = 0;
    while (!rsp_valid && n < 5000) begin
      @(negedge clk); n++;
      if (hold && n == 4) chk(req_ready == 0, "R11 ready low while busy", req_ready, 0);
    end
    req_valid = 0;
    e = rsp_err; d = rsp_data;
    chk(rsp_valid == 1, {tag, " R11 response seen"}, rsp_valid, 1);
    chk(e == v.err, {tag, " R6 R7 R8 error code"}, e, v.err);
    if (op == 2'b01) chk(d == v.rbyte, {tag, " R9 read byte D7 first"}, d, v.rbyte);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < exp_n; i++)
      if (i < log_n - base && (lt[base+i] != et[i] || lb[base+i] != eb[i])) bad++;
    chk(log_n - base == exp_n && bad == 0, {tag, " R4 R5 R10 cycle order"}, 64'(log_n - base) + 64'(bad) * 1000, 64'(exp_n));
    chk(rsp_valid == 0 && req_ready == 1, {tag, " R11 single pulse"}, {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    rv = '1;
    repeat (3) @(negedge clk);
    chk({ce_n, oe_n, we_n, io_oe, req_ready, rsp_valid} == 6'b111010, "R1 reset state",
        {ce_n, oe_n, we_n, io_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run(VEC[i], VEC[i].op, 0, $sformatf("vec%0d", i));
    run(VEC[4], 2'b01, 1, "held request");
    run(VEC[6], 2'b11, 0, "op3 poll");
    chk(werr == 0, "R2 strobe width and gap", werr, 0);
    chk(derr == 0, "R3 drive only in write", derr, 0);
    @(negedge clk);
    req_op = 0; req_addr = 9'h020; req_len = 3'd7; req_data = '1; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (30) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk({ce_n, oe_n, we_n, io_oe, req_ready, rsp_valid} == 6'b111010, "R1 reset mid write",
        {ce_n, oe_n, we_n, io_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1;
    @(negedge clk);
    run(VEC[5], 2'b01, 0, "after reset");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule